// File: doc/BRIEF.md
# Word-to-Serial Transmit Converter

This block takes 16-bit words from an upstream stream interface and sends them out as one continuous serial bit stream, one bit per serial bit clock. A free-running divide-by-16 counter produces both a word-rate clock for upstream logic and a single-cycle load pulse. On the load pulse, the word at the head of a small holding buffer is copied into a loadable shift register, which then sends the word most significant bit first. Because the word clock and the load pulse come from the same counter, they keep a fixed phase relationship. Upstream logic timed by the word clock therefore sees a stable phase against the serializer.

The bit clock comes from one of three ideal clock inputs: the synthesized clock, an external bypass clock, or the received serial clock (loop timing). A line-loopback control, active low, replaces both the serial data output and the serial clock output with the received serial data and clock. While loopback is active, the serializer keeps running behind the output multiplexer.

Input words arrive with a valid/ready handshake in the bit-clock domain. A word is accepted on a bit-clock edge where both valid and ready are high. Ready is low while the holding buffer is full. While valid is high and ready is low, upstream must keep the word and valid stable. Nothing is lost: upstream simply waits. If the buffer is empty at a load, an all-zero word is sent in its place.

Top module: `word_serial_tx`

## Requirements
- R1: Every word placed in the shift register is sent as exactly 16 consecutive serial bits, and consecutive words follow each other with no gap or repeated bit period.
- R2: Bit 15 of a word is driven on `tx_data_o` first and bit 0 last.
- R3: `word_clk_o` is the bit clock divided by 16. It is low for the 8 bit cycles in which the internal counter holds 0 to 7 and high for the 8 cycles in which it holds 8 to 15.
- R4: The load happens on the bit-clock edge where the counter wraps from 15 to 0, which is the edge where `word_clk_o` falls. Bit 15 of the new word appears in the cycle that begins at that edge. Exactly one load occurs every 16 bit cycles.
- R5: While `rst_n_i` is low, `word_clk_o` and `tx_data_o` are 0, and asserting `rst_n_i` forces them to 0 at once. After release, the counter starts at 0, `word_clk_o` first rises on the 8th bit-clock edge, and `tx_data_o` stays 0 until the first load.
- R6: `in_ready_o` is high exactly when the holding buffer, of depth `HOLD_DEPTH` (default 4), is not full. A word is accepted on an edge where `in_valid_i` and `in_ready_o` are both high, and words are sent in acceptance order.
- R7: If the holding buffer is empty at a load, the word sent is all zeros.
- R8: While `line_lpbk_n_i` is 0, `tx_data_o` equals `rx_data_i` and `tx_clk_o` equals `rx_clk_i`, and the counter keeps running. While `line_lpbk_n_i` is 1, `tx_clk_o` is the bit clock.
- R9: With `loop_time_i` at 0, `byp_sel_i` at 1 makes `byp_clk_i` the bit clock, and `byp_sel_i` at 0 makes `synth_clk_i` the bit clock.
- R10: `loop_time_i` at 1 makes `rx_clk_i` the bit clock, whatever `byp_sel_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| synth_clk_i | input | 1 | Synthesized serial bit clock (ideal) |
| byp_clk_i | input | 1 | External bypass serial bit clock |
| rx_clk_i | input | 1 | Received serial clock |
| rst_n_i | input | 1 | Master reset, active low, asynchronous |
| byp_sel_i | input | 1 | 1 selects the bypass clock as the bit clock |
| loop_time_i | input | 1 | 1 selects the received clock as the bit clock |
| line_lpbk_n_i | input | 1 | Line loopback enable, active low |
| rx_data_i | input | 1 | Received serial data |
| in_data_i | input | 16 | Parallel word from upstream |
| in_valid_i | input | 1 | Upstream word valid |
| in_ready_o | output | 1 | Holding buffer can take a word |
| word_clk_o | output | 1 | Bit clock divided by 16 |
| tx_data_o | output | 1 | Serial data output |
| tx_clk_o | output | 1 | Serial clock output |

## Verification
The hardest situation to reach from the ports is a change of bit-clock source, because the counter only shows its clock through the divided word clock. The bench gates each alternative clock input on and off. It switches sources only while every clock is low. It then counts `word_clk_o` transitions over a fixed window: none when the selected source is stopped, exactly four when it runs. A second hard case is the holding buffer staying full: the bench streams eight words back to back so that back-pressure appears while the early words are sent. It then lets the buffer drain and checks that the word after the last one is all zeros.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
  localparam int WS_WORD_W     = 16;
  localparam int WS_HOLD_DEPTH = 4;

  typedef enum logic [1:0] {
    CK_SYNTH  = 2'd0,
    CK_BYPASS = 2'd1,
    CK_RECV   = 2'd2
  } ck_src_e;

  // loop timing outranks the bypass choice
  function automatic ck_src_e pick_src(input logic loop_time, input logic byp);
    if (loop_time) return CK_RECV;
    else if (byp)  return CK_BYPASS;
    else           return CK_SYNTH;
  endfunction
endpackage

// File: rtl/ws_clk_pick.sv
`timescale 1ns/1ps
module ws_clk_pick import ws_pkg::*; (
  input  logic synth_clk_i,
  input  logic byp_clk_i,
  input  logic rx_clk_i,
  input  logic byp_sel_i,
  input  logic loop_time_i,
  output logic bit_clk_o
);
  ck_src_e src;

  always_comb begin
    src = pick_src(loop_time_i, byp_sel_i);
    case (src)
      CK_RECV:   bit_clk_o = rx_clk_i;
      CK_BYPASS: bit_clk_o = byp_clk_i;
      default:   bit_clk_o = synth_clk_i;
    endcase
  end
endmodule

// File: rtl/ws_word_timer.sv
`timescale 1ns/1ps
module ws_word_timer #(
  parameter int WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic ld_o,
  output logic wclk_o
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);
  localparam bit POW2 = ((WORD_W & (WORD_W - 1)) == 0);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign ld_o = (cnt_q == LAST);

  generate
    if (POW2) begin : g_msb
      assign wclk_o = cnt_q[CNT_W-1];
    end else begin : g_cmp
      assign wclk_o = (cnt_q >= HALF);
    end
  endgenerate

  AST_LOAD_ONCE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_o |=> !ld_o) else $error("load strobe repeated"); // R4

  AST_LOAD_HIGH_PHASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_o |-> wclk_o) else $error("load outside high half"); // R3

  AST_WCLK_FALL_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(wclk_o) |-> $past(ld_o)) else $error("word clock fell without load"); // R4
endmodule

// File: rtl/ws_hold_buf.sv
`timescale 1ns/1ps
module ws_hold_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              push_valid_i,
  output logic              push_ready_o,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic              nonempty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);
  localparam logic [PTR_W-1:0] TOP  = PTR_W'(DEPTH - 1);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q, wr_nx, rd_nx;
  logic [OCC_W-1:0]  occ_q;
  logic              push, pop;

  assign push_ready_o = (occ_q != FULL);
  assign nonempty_o   = (occ_q != '0);
  assign push         = push_valid_i & push_ready_o;
  assign pop          = pop_i & nonempty_o;
  assign head_o       = nonempty_o ? mem_q[rd_q] : '0;

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nx = wr_q + 1'b1;
      assign rd_nx = rd_q + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nx = (wr_q == TOP) ? '0 : wr_q + 1'b1;
      assign rd_nx = (rd_q == TOP) ? '0 : rd_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wr_q <= wr_nx;
      if (pop)  rd_q <= rd_nx;
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    occ_q <= FULL) else $error("holding buffer overflow"); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!push_ready_o && !pop_i) |=> !push_ready_o) else $error("full state lost"); // R6
endmodule

// File: rtl/ws_shift_out.sv
`timescale 1ns/1ps
module ws_shift_out #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  sh_q <= '0;
    else if (ld_i) sh_q <= word_i;
    else           sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign ser_o = sh_q[WORD_W-1];

  AST_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(ld_i) |-> (ser_o == $past(word_i[WORD_W-1]))) else $error("first bit not MSB"); // R2
endmodule

// File: rtl/ws_line_sel.sv
`timescale 1ns/1ps
module ws_line_sel (
  input  logic lpbk_n_i,
  input  logic ser_i,
  input  logic bit_clk_i,
  input  logic rx_data_i,
  input  logic rx_clk_i,
  output logic tx_data_o,
  output logic tx_clk_o
);
  always_comb begin
    if (!lpbk_n_i) begin
      tx_data_o = rx_data_i;
      tx_clk_o  = rx_clk_i;
    end else begin
      tx_data_o = ser_i;
      tx_clk_o  = bit_clk_i;
    end
  end
endmodule

// File: rtl/word_serial_tx.sv
`timescale 1ns/1ps
module word_serial_tx import ws_pkg::*; #(
  parameter int WORD_W     = WS_WORD_W,
  parameter int HOLD_DEPTH = WS_HOLD_DEPTH
) (
  input  logic              synth_clk_i,
  input  logic              byp_clk_i,
  input  logic              rx_clk_i,
  input  logic              rst_n_i,
  input  logic              byp_sel_i,
  input  logic              loop_time_i,
  input  logic              line_lpbk_n_i,
  input  logic              rx_data_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              word_clk_o,
  output logic              tx_data_o,
  output logic              tx_clk_o
);
  logic              bit_clk;
  logic              ld;
  logic              hold_nonempty;
  logic [WORD_W-1:0] hold_head;
  logic              ser;

  ws_clk_pick u_clk (
    .synth_clk_i (synth_clk_i),
    .byp_clk_i   (byp_clk_i),
    .rx_clk_i    (rx_clk_i),
    .byp_sel_i   (byp_sel_i),
    .loop_time_i (loop_time_i),
    .bit_clk_o   (bit_clk)
  );

  ws_word_timer #(.WORD_W(WORD_W)) u_timer (
    .clk_i   (bit_clk),
    .rst_n_i (rst_n_i),
    .ld_o    (ld),
    .wclk_o  (word_clk_o)
  );

  ws_hold_buf #(.WORD_W(WORD_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk_i        (bit_clk),
    .rst_n_i      (rst_n_i),
    .push_data_i  (in_data_i),
    .push_valid_i (in_valid_i),
    .push_ready_o (in_ready_o),
    .pop_i        (ld),
    .head_o       (hold_head),
    .nonempty_o   (hold_nonempty)
  );

  ws_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (bit_clk),
    .rst_n_i (rst_n_i),
    .ld_i    (ld),
    .word_i  (hold_head),
    .ser_o   (ser)
  );

  ws_line_sel u_line (
    .lpbk_n_i  (line_lpbk_n_i),
    .ser_i     (ser),
    .bit_clk_i (bit_clk),
    .rx_data_i (rx_data_i),
    .rx_clk_i  (rx_clk_i),
    .tx_data_o (tx_data_o),
    .tx_clk_o  (tx_clk_o)
  );

  AST_UNDERRUN_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n_i)
    (ld && !hold_nonempty) |=> !ser) else $error("underrun word not zero"); // R7
endmodule

// File: tb/word_serial_tx_tb.sv
`timescale 1ns/1ps
module word_serial_tx_tb_top;
  localparam int W = 16;
  localparam int NV = 8;

  // stimulus word in [31:16], expected reassembled serial word in [15:0]
  localparam logic [31:0] VEC [NV] = '{
    32'hA5C3_A5C3, 32'h8000_8000, 32'h0001_0001, 32'hFFFF_FFFF,
    32'h1234_1234, 32'h0F0F_0F0F, 32'hC001_C001, 32'h7FFE_7FFE
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic byp_run = 1'b0, rx_run = 1'b0;
  logic byp_clk, rx_clk;
  assign byp_clk = clk & byp_run;
  assign rx_clk  = clk & rx_run;

  logic         rst_n = 1'b0, byp_sel = 1'b0, loop_time = 1'b0;
  logic         lpbk_n = 1'b1, rx_data = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready, word_clk, tx_data, tx_clk;

  word_serial_tx dut_i (
    .synth_clk_i   (clk),
    .byp_clk_i     (byp_clk),
    .rx_clk_i      (rx_clk),
    .rst_n_i       (rst_n),
    .byp_sel_i     (byp_sel),
    .loop_time_i   (loop_time),
    .line_lpbk_n_i (lpbk_n),
    .rx_data_i     (rx_data),
    .in_data_i     (in_data),
    .in_valid_i    (in_valid),
    .in_ready_o    (in_ready),
    .word_clk_o    (word_clk),
    .tx_data_o     (tx_data),
    .tx_clk_o      (tx_clk)
  );

  int  nchk = 0, nerr = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stream feeder: drives at falling edges, acceptance known before the rising edge
  bit feed_en = 1'b0;
  int fidx = 0;
  bit will_acc = 1'b0;
  always @(negedge clk) begin
    if (will_acc) fidx++;
    if (feed_en && fidx < NV) begin
      in_valid = 1'b1;
      in_data  = VEC[fidx][31:16];
    end else begin
      in_valid = 1'b0;
    end
    #1 will_acc = in_valid & in_ready;
  end

  task automatic wait_word_start();
    logic p;
    p = word_clk;
    for (int g = 0; g < 40; g++) begin
      @(negedge clk);
      if (p === 1'b1 && word_clk === 1'b0) return;
      p = word_clk;
    end
  endtask

  task automatic get_word(output logic [W-1:0] w, output logic rdy_mid);
    wait_word_start();
    w[W-1]  = tx_data;
    rdy_mid = 1'b0;
    for (int b = W-2; b >= 0; b--) begin
      @(negedge clk);
      w[b] = tx_data;
      if (b == 7) rdy_mid = in_ready;
    end
  endtask

  task automatic count_tog(output int n);
    logic p;
    n = 0;
    p = word_clk;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (word_clk !== p) n++;
      p = word_clk;
    end
  endtask

  initial begin
    logic [W-1:0] w;
    logic         rm;
    logic [15:0]  pat;
    int           n;

    // reset state (R5)
    repeat (5) @(negedge clk);
    chk("R5 word clock in reset", {31'd0, word_clk}, 32'd0);
    chk("R5 tx data in reset", {31'd0, tx_data}, 32'd0);
    rst_n = 1'b1;
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      if (tx_data !== 1'b0) chk("R5 tx zero before first load", {31'd0, tx_data}, 32'd0);
      if (k == 7) chk("R5 word clock low at count 7", {31'd0, word_clk}, 32'd0);
      if (k == 8) chk("R5 word clock high at count 8", {31'd0, word_clk}, 32'd1);
    end

    // stream phase: first boundary loads from an empty buffer (R7)
    feed_en = 1'b1;
    get_word(w, rm);
    chk("R7 empty buffer sends zero word", {16'd0, w}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      get_word(w, rm);
      chk($sformatf("R1 R2 R4 R6 vector %0d", i), {16'd0, w}, {16'd0, VEC[i][15:0]});
      if (i == 1) chk("R6 ready low while buffer full", {31'd0, rm}, 32'd0);
      if (i == 6) chk("R6 ready high after drain", {31'd0, rm}, 32'd1);
    end
    get_word(w, rm);
    chk("R7 zero word after drain", {16'd0, w}, 32'd0);
    feed_en = 1'b0;

    // word clock shape (R3)
    wait_word_start();
    pat = '0;
    pat[0] = word_clk;
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      pat[k] = word_clk;
    end
    chk("R3 word clock low 8 high 8", {16'd0, pat}, 32'h0000_FF00);

    // line loopback (R8)
    @(negedge clk);
    lpbk_n = 1'b0; rx_run = 1'b0; rx_data = 1'b1;
    #1 chk("R8 loopback data one", {31'd0, tx_data}, 32'd1);
    @(posedge clk); #1;
    chk("R8 loopback clock follows stopped rx clock", {31'd0, tx_clk}, 32'd0);
    @(negedge clk);
    rx_run = 1'b1; rx_data = 1'b0;
    #1 chk("R8 loopback data zero", {31'd0, tx_data}, 32'd0);
    @(posedge clk); #1;
    chk("R8 loopback clock follows running rx clock", {31'd0, tx_clk}, 32'd1);
    count_tog(n);
    chk("R8 counter runs during loopback", n, 32'd4);
    lpbk_n = 1'b1; rx_run = 1'b0;
    @(posedge clk); #1;
    chk("R8 serial clock is bit clock without loopback", {31'd0, tx_clk}, 32'd1);

    // bypass clock select (R9)
    @(negedge clk);
    byp_sel = 1'b1; byp_run = 1'b0;
    count_tog(n);
    chk("R9 stopped bypass clock freezes counter", n, 32'd0);
    byp_run = 1'b1;
    count_tog(n);
    chk("R9 bypass clock drives counter", n, 32'd4);

    // loop timing overrides bypass (R10)
    loop_time = 1'b1; rx_run = 1'b0;
    count_tog(n);
    chk("R10 loop timing uses stopped rx clock", n, 32'd0);
    rx_run = 1'b1;
    count_tog(n);
    chk("R10 rx clock drives counter", n, 32'd4);
    loop_time = 1'b0; byp_sel = 1'b0; byp_run = 1'b0; rx_run = 1'b0;

    // asynchronous reset while word clock is high (R5)
    for (int g = 0; g < 20 && word_clk !== 1'b1; g++) @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R5 reset forces word clock low", {31'd0, word_clk}, 32'd0);
    chk("R5 reset forces tx data low", {31'd0, tx_data}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule